// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog

The block is a watchdog counter that escalates in two steps. Software programs two independent periods and a target hart index through a small write port, then sets an enable bit. From then on it must pulse a refresh input regularly. If the first period runs out with no refresh, the block raises a supervisor-level interrupt request and presents the chosen hart index beside it. If software still stays silent, a second countdown starts from the second period. When that countdown expires, the block raises a sticky system-level request. A more privileged agent, such as a machine-level interrupt input or reset-control logic, consumes that request.

A refresh at any point reloads the first countdown, abandons any running second countdown and withdraws the supervisor request. It does not withdraw the system-level request. Only the dedicated clear input or a reset does that. While the enable bit is low, the counters sit at their reload values and no new request can appear. Period writes made while counting are picked up at the next reload.

Top module: `wdog_two_stage`

## Requirements
- R1: Writes use `wrEn`, `wrAddr` and `wrData` and take effect at the clock edge that samples them. Address 0 bit 0 is the enable bit, address 1 is the first period, address 2 is the second period, and address 3 holds the hart index in its low `HART_W` bits.
- R2: Let the enable write be sampled at edge E, with first period P1. With no refresh, `stage1Irq` is low after edge E+P1+1 and high after edge E+P1+2. If a refresh is sampled at edge R, `stage1Irq` is next raised after edge R+P1+1.
- R3: A refresh sampled while enabled drops `stage1Irq` after that edge. It reloads the first countdown and cancels any running second countdown, so that countdown never raises `stage2Req`.
- R4: If `stage1Irq` rose after edge F and no refresh follows, `stage2Req` rises after edge F+P2+1, where P2 is the second period.
- R5: Once high, `stage2Req` stays high through refreshes. It falls only after an edge that samples `stage2Clear` high, or on reset.
- R6: Writing the enable bit to 0 drops `stage1Irq` one edge after the write takes effect. While disabled, no refresh and no amount of time raises either output. Re-enabling restarts the full first period as in R2.
- R7: `stage1Hart` is zero while `stage1Irq` is low. While `stage1Irq` is high, it holds the hart index that was programmed when the request rose, even if that register is rewritten later.
- R8: A period of zero expires on the first edge after the reload: with both periods zero, `stage1Irq` rises after edge E+2 and `stage2Req` after edge E+3.
- R9: A period write made while a countdown is running does not change that countdown. It applies from the next reload.
- R10: After reset both outputs and `stage1Hart` are low and the enable bit is clear, so no request appears without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select |
| wrData | input | CNT_W | Write data |
| refresh | input | 1 | Software refresh pulse |
| stage2Clear | input | 1 | Clears the sticky system-level request |
| stage1Irq | output | 1 | Supervisor-level interrupt request |
| stage1Hart | output | HART_W | Hart index paired with `stage1Irq` |
| stage2Req | output | 1 | Sticky system-level request |

## Verification
Most internal faults show up as an error in timing at the outputs. A countdown that reloads from the wrong register, or a phase that fails to advance, moves the rising edge of `stage1Irq` or `stage2Req` by one or more cycles. The bench checks the exact cycle of each rise, and also checks the cycle just before it. A lost cancel on refresh shows up as a `stage2Req` that appears where none is due. That happens within the second period after the refresh. A wrong capture of the hart index appears on `stage1Hart` in the first cycle the request is high.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_P1   = 2'd1;
  localparam logic [1:0] ADDR_P2   = 2'd2;
  localparam logic [1:0] ADDR_HART = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_FIRST   = 2'd1,
    PH_SECOND  = 2'd2,
    PH_EXPIRED = 2'd3
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load1;
    logic dec1;
    logic load2;
    logic dec2;
    logic capHart;
    logic dropHart;
  } dp_ctrl_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HART_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  dp_ctrl_t          ctl,
  output logic              enableQ,
  output logic              cnt1Zero,
  output logic              cnt2Zero,
  output logic [HART_W-1:0] hartOut
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  period1Q;
  logic [CNT_W-1:0]  period2Q;
  logic [HART_W-1:0] hartQ;
  logic [CNT_W-1:0]  cnt1;
  logic [CNT_W-1:0]  cnt2;

  // R1: configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      period1Q <= '0;
      period2Q <= '0;
      hartQ    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: enableQ  <= wrData[0];
        ADDR_P1:   period1Q <= wrData;
        ADDR_P2:   period2Q <= wrData;
        default:   hartQ    <= wrData[HART_W-1:0];
      endcase
    end
  end

  // first-stage countdown; reload reads the register, so R9 holds
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt1 <= '0;
    end else if (ctl.load1) begin
      cnt1 <= period1Q;
    end else if (ctl.dec1) begin
      cnt1 <= cnt1 - CNT_ONE;
    end
  end

  // second-stage countdown
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt2 <= '0;
    end else if (ctl.load2) begin
      cnt2 <= period2Q;
    end else if (ctl.dec2) begin
      cnt2 <= cnt2 - CNT_ONE;
    end
  end

  // R7: hart index frozen when the first-stage request rises
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hartOut <= '0;
    end else if (ctl.capHart) begin
      hartOut <= hartQ;
    end else if (ctl.dropHart) begin
      hartOut <= '0;
    end
  end

  assign cnt1Zero = (cnt1 == '0);
  assign cnt2Zero = (cnt2 == '0);

  // a countdown never wraps: decrement is only requested above zero
  a_r2_no_wrap1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dec1 |-> !cnt1Zero);
  a_r4_no_wrap2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.dec2 |-> !cnt2Zero);

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     refresh,
  input  logic     stage2Clear,
  input  logic     enableQ,
  input  logic     cnt1Zero,
  input  logic     cnt2Zero,
  output dp_ctrl_t ctl,
  output logic     stage1Irq,
  output logic     stage2Req
);

  phase_t phase;
  phase_t phaseNext;
  logic   set1;
  logic   clr1;
  logic   set2;

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    set1      = 1'b0;
    clr1      = 1'b0;
    set2      = 1'b0;
    if (!enableQ) begin
      // R6: hold both counters at reload, withdraw stage one
      phaseNext    = PH_IDLE;
      ctl.load1    = 1'b1;
      ctl.load2    = 1'b1;
      ctl.dropHart = 1'b1;
      clr1         = 1'b1;
    end else begin
      case (phase)
        PH_IDLE: begin
          phaseNext = PH_FIRST;
          ctl.load1 = 1'b1;
          ctl.load2 = 1'b1;
        end
        PH_FIRST: begin
          if (refresh) begin
            ctl.load1 = 1'b1;
          end else if (cnt1Zero) begin
            set1        = 1'b1;
            ctl.capHart = 1'b1;
            ctl.load2   = 1'b1;
            phaseNext   = PH_SECOND;
          end else begin
            ctl.dec1 = 1'b1;
          end
        end
        PH_SECOND: begin
          if (refresh) begin
            ctl.load1    = 1'b1;
            ctl.dropHart = 1'b1;
            clr1         = 1'b1;
            phaseNext    = PH_FIRST;
          end else if (cnt2Zero) begin
            set2      = 1'b1;
            phaseNext = PH_EXPIRED;
          end else begin
            ctl.dec2 = 1'b1;
          end
        end
        default: begin
          if (refresh) begin
            ctl.load1    = 1'b1;
            ctl.dropHart = 1'b1;
            clr1         = 1'b1;
            phaseNext    = PH_FIRST;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phaseNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1Irq <= 1'b0;
    end else if (set1) begin
      stage1Irq <= 1'b1;
    end else if (clr1) begin
      stage1Irq <= 1'b0;
    end
  end

  // R5: sticky, only the clear input or reset drops it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage2Req <= 1'b0;
    end else if (set2) begin
      stage2Req <= 1'b1;
    end else if (stage2Clear) begin
      stage2Req <= 1'b0;
    end
  end

  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |=> !stage1Irq);
  a_r6_no_stage2_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!enableQ && !stage2Req) |=> !stage2Req);
  a_r3_refresh_drops: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && refresh) |=> !stage1Irq);
  a_r4_stage2_after_stage1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stage2Req) |-> stage1Irq);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (stage2Req && !stage2Clear) |=> stage2Req);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int HART_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              refresh,
  input  logic              stage2Clear,
  output logic              stage1Irq,
  output logic [HART_W-1:0] stage1Hart,
  output logic              stage2Req
);

  dp_ctrl_t ctl;
  logic     enableQ;
  logic     cnt1Zero;
  logic     cnt2Zero;

  wdog_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .refresh     (refresh),
    .stage2Clear (stage2Clear),
    .enableQ     (enableQ),
    .cnt1Zero    (cnt1Zero),
    .cnt2Zero    (cnt2Zero),
    .ctl         (ctl),
    .stage1Irq   (stage1Irq),
    .stage2Req   (stage2Req)
  );

  wdog_datapath #(
    .CNT_W  (CNT_W),
    .HART_W (HART_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .ctl      (ctl),
    .enableQ  (enableQ),
    .cnt1Zero (cnt1Zero),
    .cnt2Zero (cnt2Zero),
    .hartOut  (stage1Hart)
  );

  a_r7_hart_hold: assert property (@(posedge clk) disable iff (!rstN)
    (stage1Irq && $past(stage1Irq)) |-> $stable(stage1Hart));
  a_r7_hart_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !stage1Irq |-> (stage1Hart == '0));

endmodule

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

  localparam int CNT_W  = 16;
  localparam int HART_W = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrAddr = '0;
  logic [CNT_W-1:0]  wrData = '0;
  logic              refresh = 1'b0;
  logic              stage2Clear = 1'b0;
  logic              stage1Irq;
  logic [HART_W-1:0] stage1Hart;
  logic              stage2Req;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    int    at;
    int    kind;   // 0 stage1Irq, 1 stage2Req, 2 stage1Hart
    int    val;
    string tag;
  } exp_t;

  exp_t sb[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  wdog_two_stage #(.CNT_W(CNT_W), .HART_W(HART_W)) i_wdog_two_stage (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .refresh(refresh), .stage2Clear(stage2Clear),
    .stage1Irq(stage1Irq), .stage1Hart(stage1Hart), .stage2Req(stage2Req)
  );

  task automatic expect1(input int at, input int v, input string tag);
    sb.push_back('{at, 0, v, tag});
  endtask
  task automatic expect2(input int at, input int v, input string tag);
    sb.push_back('{at, 1, v, tag});
  endtask
  task automatic expectH(input int at, input int v, input string tag);
    sb.push_back('{at, 2, v, tag});
  endtask

  // monitor: compare due items between edges
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at <= cyc) begin
        int act;
        act = (sb[i].kind == 0) ? int'(stage1Irq) :
              (sb[i].kind == 1) ? int'(stage2Req) : int'(stage1Hart);
        checks++;
        if (sb[i].at < cyc || act != sb[i].val) begin
          errors++;
          $display("FAIL %s cycle %0d kind %0d: actual %0d expected %0d",
                   sb[i].tag, sb[i].at, sb[i].kind, act, sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic waitUntil(input int c);
    while (cyc < c) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(input logic [1:0] a, input int d, output int e);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = CNT_W'(d);
    @(posedge clk); #1;
    wrEn = 1'b0;
    e = cyc;
  endtask

  task automatic pulseRefresh(output int e);
    @(negedge clk);
    refresh = 1'b1;
    @(posedge clk); #1;
    refresh = 1'b0;
    e = cyc;
  endtask

  task automatic pulseClear(output int e);
    @(negedge clk);
    stage2Clear = 1'b1;
    @(posedge clk); #1;
    stage2Clear = 1'b0;
    e = cyc;
  endtask

  task automatic setup(input int p1, input int p2, input int h, output int e);
    int t;
    regWrite(2'd0, 0, t);
    pulseClear(t);
    regWrite(2'd1, p1, t);
    regWrite(2'd2, p2, t);
    regWrite(2'd3, h, t);
    regWrite(2'd0, 1, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int e, r, w, c, d, e2, d2;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R10: reset state, nothing happens without a write
    expect1(cyc + 1, 0, "R10");
    expect2(cyc + 1, 0, "R10");
    expectH(cyc + 1, 0, "R10");
    expect1(cyc + 10, 0, "R10");
    waitUntil(cyc + 11);

    // R1 R2 R4 R7: plain escalation, P1=5 P2=3 hart 7
    setup(5, 3, 7, e);
    expect1(e + 6, 0, "R2");
    expectH(e + 6, 0, "R7");
    expect1(e + 7, 1, "R2");
    expectH(e + 7, 7, "R1 R7");
    expect2(e + 7, 0, "R4");
    expect2(e + 10, 0, "R4");
    expect2(e + 11, 1, "R4");
    waitUntil(e + 12);

    // R3 R5: refresh drops stage one, stage two stays
    pulseRefresh(r);
    expect1(r + 1, 0, "R3");
    expect2(r + 1, 1, "R5");
    expect1(r + 5, 0, "R2");
    expect1(r + 6, 1, "R2");
    waitUntil(r + 7);
    regWrite(2'd3, 3, w);
    expectH(w + 1, 7, "R7");
    expect1(w + 1, 1, "R7");
    waitUntil(r + 12);
    pulseClear(c);
    expect2(c + 1, 0, "R5");
    expect2(c + 4, 0, "R5");
    waitUntil(c + 5);

    // R3: refresh during second countdown cancels it
    setup(4, 6, 2, e);
    expect1(e + 6, 1, "R2");
    expectH(e + 6, 2, "R7");
    waitUntil(e + 8);
    pulseRefresh(r);
    expect1(r + 1, 0, "R3");
    expectH(r + 1, 0, "R7");
    expect2(e + 13, 0, "R3");
    expect1(r + 5, 1, "R2");
    expect2(r + 11, 0, "R4");
    expect2(r + 12, 1, "R4");
    waitUntil(r + 13);

    // R9: mid-count period write applies at next reload
    setup(6, 10, 1, e);
    regWrite(2'd1, 1, w);
    expect1(e + 7, 0, "R9");
    expect1(e + 8, 1, "R9");
    waitUntil(e + 9);
    pulseRefresh(r);
    expect1(r + 1, 0, "R3");
    expect1(r + 2, 1, "R9");
    expect2(e + 19, 0, "R3");
    expect2(r + 12, 0, "R4");
    expect2(r + 13, 1, "R4");
    waitUntil(r + 14);

    // R8: zero periods
    setup(0, 0, 5, e);
    expect1(e + 1, 0, "R8");
    expect1(e + 2, 1, "R8");
    expectH(e + 2, 5, "R8");
    expect2(e + 2, 0, "R8");
    expect2(e + 3, 1, "R8");
    waitUntil(e + 4);

    // R6: disable while counting, refresh while off, re-enable
    setup(3, 2, 4, e);
    regWrite(2'd0, 0, d);
    expect1(e + 5, 0, "R6");
    expect1(e + 12, 0, "R6");
    expect2(e + 12, 0, "R6");
    waitUntil(e + 14);
    pulseRefresh(r);
    expect1(r + 3, 0, "R6");
    expect1(r + 6, 0, "R6");
    waitUntil(r + 7);
    regWrite(2'd0, 1, e2);
    expect1(e2 + 4, 0, "R6");
    expect1(e2 + 5, 1, "R6");
    expectH(e2 + 5, 4, "R7");
    waitUntil(e2 + 5);
    regWrite(2'd0, 0, d2);
    expect1(d2, 1, "R6");
    expect1(d2 + 1, 0, "R6");
    expectH(d2 + 1, 0, "R7");
    expect2(e2 + 9, 0, "R6");
    expect2(e2 + 12, 0, "R6");
    waitUntil(e2 + 14);

    if (sb.size() != 0) begin
      errors += sb.size();
      checks += sb.size();
      $display("FAIL scoreboard: actual %0d unchecked expected 0", sb.size());
    end
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule